// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide programming interface of a single eight-line interrupt controller. Software writes and reads it through a one-bit address and a data byte. A write to address 0 with bit 4 set starts an initialization sequence. The sequence then takes its further words from address 1, in a fixed order. Outside that sequence, writes to address 0 are operational commands. These cover end-of-interrupt variants, priority rotation, read-register selection, special mask and poll. Writes to address 1 load the interrupt mask. A separate strobe loads the trigger-mode register, and a per-instance constant limits which of its bits are writable.

The block holds the configuration that the neighbouring priority resolver uses: mask, vector base, priority offset and mode flags. It takes the live request and in-service vectors from the resolver. It sends back one-cycle clear pulses for in-service and request bits. These pulses come from end-of-interrupt commands and poll reads. It holds no request or in-service state of its own. Reads are registered: data and a valid flag appear one cycle after the read strobe.

Priority is rotating. A line's rank is (line - offset) mod 8, and rank 0 is the highest priority.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset the following are all zero: mask, vector base, priority offset, every mode flag, the trigger-mode register, both clear-pulse vectors and the read-valid flag.
- R2: A write to address 0 with data bit 4 set starts initialization. It stores data bit 0 as "mode word expected" and clears the mask, priority offset, special mask and read select. When data bit 0 is 0 it also clears nested mode and auto-EOI; when bit 0 is 1 it leaves them unchanged.
- R3: During initialization, the address-1 writes are taken in order. The first sets the vector base to data AND 0xF8. The second is ignored. A third, taken only when a mode word is expected, sets nested mode from data bit 4 and auto-EOI from data bit 1. After the last word of the sequence, address 1 goes back to loading the mask.
- R4: Outside initialization, a write to address 1 loads the mask register with the data byte.
- R5: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a read/poll command. Bit 2 = 1 arms poll. When bit 1 = 1, bit 0 selects the in-service vector (1) or the request vector (0) for address-0 reads; otherwise the selection is kept. When bit 6 = 1, bit 5 becomes the special-mask flag; otherwise that flag is kept.
- R6: A write to address 0 with bits 4 and 3 both 0 carries a command code in data bits 7:5. Code 0 clears rotate-on-auto-EOI and code 4 sets it. Code 2 changes nothing and pulses nothing.
- R7: Codes 1 and 5 pulse the in-service clear bit of the highest-priority set in-service line, one cycle after the write. Code 5 also sets the offset to that line + 1 (mod 8). When no in-service bit is set, neither code pulses or changes the offset.
- R8: Code 3 pulses the in-service clear for line (data AND 7) and leaves the offset unchanged. Code 7 does the same and also sets the offset to that line + 1 (mod 8). Code 6 sets the offset to (data + 1) mod 8 without pulsing.
- R9: A read with poll disarmed gives rd_valid high one cycle later. The data returned at address 0 is the in-service or request vector, as selected; at address 1 it is the mask.
- R10: A read with poll armed disarms poll. The winner is the highest-priority unmasked request, and it wins only if its rank is lower than the rank of the highest in-service line (or no in-service bit is set). If there is a winner, the read returns its line number and pulses both the request-clear and in-service-clear bits for that line. If there is no winner, the read returns 7 and pulses nothing.
- R11: A trigger-mode write stores data AND TRIG_WMASK (default 0xF8).
- R12: A read strobe that comes in the same cycle as a write strobe is ignored: rd_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data byte |
| trig_wr | input | 1 | Trigger-mode register write strobe (uses wdata) |
| irr_in | input | 8 | Live request vector from resolver |
| isr_in | input | 8 | Live in-service vector from resolver |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Registered read data |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base (low three bits zero) |
| prio_off | output | 3 | Rotating priority offset |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi | output | 1 | Rotate on auto end-of-interrupt |
| nested | output | 1 | Special nested mode |
| spec_mask | output | 1 | Special mask mode |
| trig_mode | output | 8 | Level-trigger select per line |
| eoi_clr | output | 8 | One-cycle in-service clear pulses |
| req_clr | output | 8 | One-cycle request clear pulses |

## Verification
Every result of this block is registered once. Configuration fields, clear pulses, rd_data and rd_valid all take their new value at the clock edge that samples the strobe, and the pulses last exactly that one cycle. Each stimulus task therefore asserts its strobe for one cycle and drops it at the next falling edge. The checks then sample at that falling edge, half a period after the result edge and before the pulse can end. Because request and in-service vectors are plain inputs, the bench fixes them before each command or poll, so the expected winner can be worked out by hand.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_SKIP = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;

  typedef enum logic [2:0] {
    CMD_ROT_OFF = 3'd0,
    CMD_NS_EOI  = 3'd1,
    CMD_NOP     = 3'd2,
    CMD_SP_EOI  = 3'd3,
    CMD_ROT_ON  = 3'd4,
    CMD_ROT_NS  = 3'd5,
    CMD_SET_PRI = 3'd6,
    CMD_ROT_SP  = 3'd7
  } cmd_e;
endpackage

// File: rtl/pic_rot_prio.sv
module pic_rot_prio #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] off,
  output logic          found,
  output logic [LW-1:0] line,
  output logic [LW-1:0] rank
);
  logic [N-1:0] rot;

  // rot[k] is the line whose rank is k
  for (genvar k = 0; k < N; k++) begin : g_rot
    localparam logic [LW-1:0] K = LW'(k);
    assign rot[k] = vec[off + K];
  end

  always_comb begin
    found = 1'b0;
    rank  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        found = 1'b1;
        rank  = LW'(k);
      end
    end
    line = off + rank;
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     step,
  input  logic     need_mode,
  output init_st_e st
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else if (start) begin
      st <= ST_BASE;
    end else if (step) begin
      unique case (st)
        ST_BASE: st <= ST_SKIP;
        ST_SKIP: st <= need_mode ? ST_MODE : ST_IDLE;
        ST_MODE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_mode_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MODE && step && !start) |=> st == ST_IDLE);
  assert_skip_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP && step && !start && !need_mode) |=> st == ST_IDLE);
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cmd_pkg::*;
#(
  parameter int N = 8,
  parameter logic [N-1:0] TRIG_WMASK = 8'hF8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [N-1:0]    wdata,
  input  logic            trig_wr,
  input  logic [N-1:0]    irr_in,
  input  logic [N-1:0]    isr_in,
  output logic            rd_valid,
  output logic [N-1:0]    rd_data,
  output logic [N-1:0]    imr,
  output logic [N-1:0]    vec_base,
  output logic [$clog2(N)-1:0] prio_off,
  output logic            auto_eoi,
  output logic            rot_aeoi,
  output logic            nested,
  output logic            spec_mask,
  output logic [N-1:0]    trig_mode,
  output logic [N-1:0]    eoi_clr,
  output logic [N-1:0]    req_clr
);
  localparam int LW = $clog2(N);
  localparam logic [N-1:0] BASE_MASK = {N{1'b1}} << LW;
  localparam logic [LW-1:0] ONE = LW'(1);

  logic need4_q, sel_isr_q, poll_q;
  init_st_e st;

  logic wr0, wr1, start_w, rw_cmd, op_cmd, rd_ok;
  cmd_e cmd;
  logic [LW-1:0] data_line;

  assign wr0       = wr_en && !addr;
  assign wr1       = wr_en && addr;
  assign start_w   = wr0 && wdata[4];
  assign rw_cmd    = wr0 && !wdata[4] && wdata[3];
  assign op_cmd    = wr0 && !wdata[4] && !wdata[3];
  assign cmd       = cmd_e'(wdata[7:5]);
  assign data_line = wdata[LW-1:0];
  assign rd_ok     = rd_en && !wr_en;

  logic          isr_found, req_found, poll_hit;
  logic [LW-1:0] isr_line, isr_rank, req_line, req_rank;

  pic_rot_prio #(.N(N), .LW(LW)) u_isr_prio (
    .vec(isr_in), .off(prio_off),
    .found(isr_found), .line(isr_line), .rank(isr_rank)
  );

  pic_rot_prio #(.N(N), .LW(LW)) u_req_prio (
    .vec(irr_in & ~imr), .off(prio_off),
    .found(req_found), .line(req_line), .rank(req_rank)
  );

  assign poll_hit = req_found && (!isr_found || (req_rank < isr_rank));

  pic_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .step(wr1),
    .need_mode(need4_q), .st(st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need4_q   <= 1'b0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
      imr       <= '0;
      vec_base  <= '0;
      prio_off  <= '0;
      auto_eoi  <= 1'b0;
      rot_aeoi  <= 1'b0;
      nested    <= 1'b0;
      spec_mask <= 1'b0;
      trig_mode <= '0;
      eoi_clr   <= '0;
      req_clr   <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      eoi_clr  <= '0;
      req_clr  <= '0;
      rd_valid <= rd_ok;

      if (trig_wr) trig_mode <= wdata & TRIG_WMASK;

      if (start_w) begin
        need4_q   <= wdata[0];
        imr       <= '0;
        prio_off  <= '0;
        spec_mask <= 1'b0;
        sel_isr_q <= 1'b0;
        if (!wdata[0]) begin
          nested   <= 1'b0;
          auto_eoi <= 1'b0;
        end
      end else if (wr1) begin
        unique case (st)
          ST_IDLE: imr      <= wdata;
          ST_BASE: vec_base <= wdata & BASE_MASK;
          ST_SKIP: ;
          ST_MODE: begin
            nested   <= wdata[4];
            auto_eoi <= wdata[1];
          end
          default: ;
        endcase
      end else if (rw_cmd) begin
        if (wdata[2]) poll_q    <= 1'b1;
        if (wdata[1]) sel_isr_q <= wdata[0];
        if (wdata[6]) spec_mask <= wdata[5];
      end else if (op_cmd) begin
        unique case (cmd)
          CMD_ROT_OFF, CMD_ROT_ON: rot_aeoi <= wdata[7];
          CMD_NS_EOI, CMD_ROT_NS: begin
            if (isr_found) begin
              eoi_clr <= N'(1) << isr_line;
              if (cmd == CMD_ROT_NS) prio_off <= isr_line + ONE;
            end
          end
          CMD_SP_EOI:  eoi_clr <= N'(1) << data_line;
          CMD_SET_PRI: prio_off <= data_line + ONE;
          CMD_ROT_SP: begin
            eoi_clr  <= N'(1) << data_line;
            prio_off <= data_line + ONE;
          end
          default: ;
        endcase
      end

      if (rd_ok) begin
        if (poll_q) begin
          poll_q <= 1'b0;
          if (poll_hit) begin
            rd_data <= N'(req_line);
            req_clr <= N'(1) << req_line;
            eoi_clr <= N'(1) << req_line;
          end else begin
            rd_data <= N'(N - 1);
          end
        end else if (addr) begin
          rd_data <= imr;
        end else begin
          rd_data <= sel_isr_q ? isr_in : irr_in;
        end
      end
    end
  end

  assert_eoi_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_clr));
  assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> rd_valid);
  assert_rd_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_valid);
  assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (imr == '0 && prio_off == '0 && !spec_mask));
  assert_poll_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr != '0) |-> (req_clr == eoi_clr && rd_valid));
  assert_poll_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && poll_q) |=> !poll_q);
endmodule

// File: tb/sim_pic_cmd_port.sv
module sim_pic_cmd_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, trig_wr = 1'b0;
  logic [7:0] wdata = '0, irr_in = '0, isr_in = '0;
  logic rd_valid, auto_eoi, rot_aeoi, nested, spec_mask;
  logic [7:0] rd_data, imr, vec_base, trig_mode, eoi_clr, req_clr;
  logic [2:0] prio_off;
  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  pic_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .trig_wr(trig_wr), .irr_in(irr_in), .isr_in(isr_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .imr(imr), .vec_base(vec_base),
    .prio_off(prio_off), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
    .nested(nested), .spec_mask(spec_mask), .trig_mode(trig_mode),
    .eoi_clr(eoi_clr), .req_clr(req_clr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 imr", imr, 8'h00);
    chk("R1 vec_base", vec_base, 8'h00);
    chk("R1 prio_off", {5'b0, prio_off}, 8'h00);
    chk("R1 flags", {4'b0, auto_eoi, rot_aeoi, nested, spec_mask}, 8'h00);
    chk("R1 trig_mode", trig_mode, 8'h00);
    chk("R1 pulses", eoi_clr | req_clr, 8'h00);
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
  endtask

  task automatic t_init_long;
    wr(1, 8'h5A); chk("R4 mask load", imr, 8'h5A);
    wr(0, 8'h11); chk("R2 mask cleared", imr, 8'h00);
    wr(1, 8'h4D); chk("R3 base", vec_base, 8'h48);
    chk("R3 base not mask", imr, 8'h00);
    wr(1, 8'hAA); chk("R3 third ignored", imr, 8'h00);
    wr(1, 8'h12); chk("R3 mode word", {6'b0, nested, auto_eoi}, 8'h03);
    chk("R3 mode not mask", imr, 8'h00);
    wr(1, 8'h5A); chk("R4 mask after init", imr, 8'h5A);
    wr(0, 8'h11); chk("R2 keep modes", {6'b0, nested, auto_eoi}, 8'h03);
    chk("R2 mask cleared again", imr, 8'h00);
    wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h12);
  endtask

  task automatic t_init_short;
    wr(0, 8'h10); chk("R2 modes cleared", {6'b0, nested, auto_eoi}, 8'h00);
    wr(1, 8'h08); chk("R3 base short", vec_base, 8'h08);
    wr(1, 8'h33); chk("R3 third short", imr, 8'h00);
    wr(1, 8'h44); chk("R3 no mode word", imr, 8'h44);
    chk("R3 modes still clear", {6'b0, nested, auto_eoi}, 8'h00);
  endtask

  task automatic t_readsel;
    irr_in = 8'h81; isr_in = 8'h18;
    wr(0, 8'h0B); rd(0);
    chk("R5 select isr", rd_data, 8'h18);
    chk("R9 rd_valid", {7'b0, rd_valid}, 8'h01);
    wr(0, 8'h08); rd(0); chk("R5 select kept", rd_data, 8'h18);
    wr(0, 8'h0A); rd(0); chk("R5 select irr", rd_data, 8'h81);
    rd(1); chk("R9 mask read", rd_data, 8'h44);
    wr(0, 8'h68); chk("R5 spec mask set", {7'b0, spec_mask}, 8'h01);
    wr(0, 8'h28); chk("R5 spec mask kept", {7'b0, spec_mask}, 8'h01);
    wr(0, 8'h48); chk("R5 spec mask clr", {7'b0, spec_mask}, 8'h00);
  endtask

  task automatic t_rotate;
    wr(0, 8'h80); chk("R6 rot set", {7'b0, rot_aeoi}, 8'h01);
    wr(0, 8'h40); chk("R6 nop rot", {7'b0, rot_aeoi}, 8'h01);
    chk("R6 nop pulse", eoi_clr, 8'h00);
    chk("R6 nop offset", {5'b0, prio_off}, 8'h00);
    wr(0, 8'h00); chk("R6 rot clr", {7'b0, rot_aeoi}, 8'h00);
  endtask

  task automatic t_ns_eoi;
    isr_in = 8'h24;
    wr(0, 8'h20); chk("R7 ns pulse", eoi_clr, 8'h04);
    chk("R7 ns offset", {5'b0, prio_off}, 8'h00);
    wr(0, 8'hA0); chk("R7 rot pulse", eoi_clr, 8'h04);
    chk("R7 rot offset", {5'b0, prio_off}, 8'h03);
    wr(0, 8'h20); chk("R7 rotated pick", eoi_clr, 8'h20);
    isr_in = 8'h00;
    wr(0, 8'hA0); chk("R7 empty pulse", eoi_clr, 8'h00);
    chk("R7 empty offset", {5'b0, prio_off}, 8'h03);
  endtask

  task automatic t_sp_eoi;
    wr(0, 8'h65); chk("R8 specific pulse", eoi_clr, 8'h20);
    chk("R8 specific offset", {5'b0, prio_off}, 8'h03);
    wr(0, 8'hE6); chk("R8 rot specific pulse", eoi_clr, 8'h40);
    chk("R8 rot specific offset", {5'b0, prio_off}, 8'h07);
    wr(0, 8'hC2); chk("R8 set prio offset", {5'b0, prio_off}, 8'h03);
    chk("R8 set prio pulse", eoi_clr, 8'h00);
  endtask

  task automatic t_poll;
    wr(0, 8'hC7); wr(1, 8'h01);
    irr_in = 8'h0B; isr_in = 8'h08;
    wr(0, 8'h0A); wr(0, 8'h0C); rd(0);
    chk("R10 poll line", rd_data, 8'h01);
    chk("R10 poll req clr", req_clr, 8'h02);
    chk("R10 poll isr clr", eoi_clr, 8'h02);
    rd(0); chk("R10 disarmed", rd_data, 8'h0B);
    chk("R10 disarmed pulse", req_clr, 8'h00);
    irr_in = 8'h10; isr_in = 8'h04;
    wr(0, 8'h0C); rd(0);
    chk("R10 blocked gives 7", rd_data, 8'h07);
    chk("R10 blocked pulses", req_clr | eoi_clr, 8'h00);
    wr(0, 8'hC4); irr_in = 8'h21; isr_in = 8'h00;
    wr(0, 8'h0C); rd(0);
    chk("R10 rotated line", rd_data, 8'h05);
    chk("R10 rotated clr", req_clr, 8'h20);
  endtask

  task automatic t_trig;
    @(negedge clk); trig_wr = 1'b1; wdata = 8'hFF;
    @(negedge clk); trig_wr = 1'b0;
    chk("R11 trig masked", trig_mode, 8'hF8);
    @(negedge clk); trig_wr = 1'b1; wdata = 8'h07;
    @(negedge clk); trig_wr = 1'b0;
    chk("R11 trig low bits", trig_mode, 8'h00);
  endtask

  task automatic t_collide;
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 1'b1; wdata = 8'h3C;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 read dropped", {7'b0, rd_valid}, 8'h00);
    chk("R12 write taken", imr, 8'h3C);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_long();
    t_init_short();
    t_readsel();
    t_rotate();
    t_ns_eoi();
    t_sp_eoi();
    t_poll();
    t_trig();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule